// File: doc/BRIEF.md
# Delay-Slot Squash Redirect Generator

This block sits in the execute stage of a pipelined processor whose instruction set has branch delay slots. Several execution lanes resolve instructions in the same cycle. Each lane reports its own instruction's address, the address that follows it, and the address after that. It also reports a sequence number and a squash cause: a branch mispredict, a memory-order violation or a blocked memory access. From these inputs the block builds a single redirect record for the commit and fetch logic.

Because of the delay slot, the restart point is a pair of addresses rather than one target. The record also says whether the squashing branch was taken. That flag is inferred from sequential-address checks that allow for the delay slot. When several lanes squash in the same cycle, the oldest instruction decides the record. The record is registered and lasts one cycle. The block covers a single thread.

Top module: `squash_redirect_gen`

## Requirements
- R1: While reset is held, and in any cycle with no redirect, every output of the record is zero.
- R2: For a branch mispredict, the taken flag is 0 only when NNPC equals NPC+4 and NPC equals PC+4 or PC+8. In every other case it is 1. Instructions are 4 bytes.
- R3: A branch mispredict (cause code 0) sets the squash, mispredict and squash-delay-slot flags. It restarts at the instruction's NPC as the restart PC and its NNPC as the restart NPC, and clears include-self.
- R4: A memory-order violation (cause code 1) sets squash only. It restarts at NPC/NNPC and clears include-self, mispredict, taken and squash-delay-slot.
- R5: A blocked memory access (cause code 2) sets squash and include-self. It restarts at the instruction's own PC with its NPC as the restart NPC. Mispredict, taken and squash-delay-slot are cleared.
- R6: The record appears on the outputs in the cycle after the lane inputs are sampled. It lasts exactly one cycle unless a new squash is presented.
- R7: When several lanes request a squash in the same cycle, the lane with the lowest sequence number supplies the record. On equal sequence numbers, the lowest-numbered lane wins.
- R8: A lane whose valid bit is low, or whose cause code is 3, is ignored.
- R9: The record's sequence number output equals the winning instruction's sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | LANES | Per-lane resolved-instruction valid |
| in_cause | input | 2*LANES | Per-lane cause code, lane i at bits [2i+1:2i] |
| in_pc | input | AW*LANES | Per-lane instruction PC |
| in_npc | input | AW*LANES | Per-lane next PC |
| in_nnpc | input | AW*LANES | Per-lane next-next PC |
| in_seq | input | SW*LANES | Per-lane sequence number |
| rd_squash | output | 1 | Redirect record valid / squash |
| rd_mispredict | output | 1 | Squash caused by branch mispredict |
| rd_taken | output | 1 | Squashing branch was taken |
| rd_squash_ds | output | 1 | Delay slot is squashed too |
| rd_pc | output | AW | Restart PC |
| rd_npc | output | AW | Restart next PC |
| rd_seq | output | SW | Sequence number of the squashing instruction |
| rd_incl_self | output | 1 | Squashing instruction is itself squashed |

## Verification
The bench aims at the sequential-address boundaries of the taken rule: a fall-through of one word and a skip of two words are both not-taken, while any other NPC step, or an NNPC that breaks sequence, is taken. A design that tested only the one-word step would report a branch that skips its delay slot as taken. The bench also checks the restart pair for each cause: a blocked access that restarted at NPC would lose the instruction that has to be replayed. Finally, it covers ties and inversions in sequence numbers across lanes, and cause code 3. A picker that favours lane order over age, or that treats code 3 as a squash, would produce a record from the wrong instruction.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
   typedef enum logic [1:0] {
      SQ_BRANCH    = 2'd0,
      SQ_MEM_ORDER = 2'd1,
      SQ_MEM_BLOCK = 2'd2,
      SQ_NONE      = 2'd3
   } squash_cause_e;
endpackage

// File: rtl/sqr_lane_decode.sv
module sqr_lane_decode
   import sqr_pkg::*;
#(
   parameter int AW  = 64,
   parameter int ISZ = 4
) (
   input  logic          valid,
   input  logic [1:0]    cause,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] npc,
   input  logic [AW-1:0] nnpc,
   output logic          req,
   output logic          mispred,
   output logic          taken,
   output logic          squash_ds,
   output logic          incl_self,
   output logic [AW-1:0] rpc,
   output logic [AW-1:0] rnpc
);
   localparam logic [AW-1:0] STEP1 = AW'(ISZ);
   localparam logic [AW-1:0] STEP2 = AW'(2 * ISZ);

   logic seq_tail, seq_head, br_taken;

   assign seq_tail = (nnpc == npc + STEP1);
   assign seq_head = (npc == pc + STEP1) || (npc == pc + STEP2);
   assign br_taken = !(seq_tail && seq_head);

   always_comb begin
      req       = 1'b0;
      mispred   = 1'b0;
      taken     = 1'b0;
      squash_ds = 1'b0;
      incl_self = 1'b0;
      rpc       = npc;
      rnpc      = nnpc;
      if (valid) begin
         case (squash_cause_e'(cause))
            SQ_BRANCH: begin
               req       = 1'b1;
               mispred   = 1'b1;
               taken     = br_taken;
               squash_ds = 1'b1;
            end
            SQ_MEM_ORDER: begin
               req = 1'b1;
            end
            SQ_MEM_BLOCK: begin
               req       = 1'b1;
               incl_self = 1'b1;
               rpc       = pc;
               rnpc      = npc;
            end
            default: req = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/sqr_oldest_pick.sv
module sqr_oldest_pick #(
   parameter int LANES = 3,
   parameter int SW    = 16,
   localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0]    req,
   input  logic [SW*LANES-1:0] seq,
   output logic                any,
   output logic [IW-1:0]       idx
);
   logic [SW-1:0] best_seq;

   always_comb begin
      any      = 1'b0;
      idx      = '0;
      best_seq = '0;
      for (int i = 0; i < LANES; i++) begin
         if (req[i] && (!any || seq[i*SW +: SW] < best_seq)) begin
            any      = 1'b1;
            idx      = IW'(i);
            best_seq = seq[i*SW +: SW];
         end
      end
   end
endmodule

// File: rtl/squash_redirect_gen.sv
module squash_redirect_gen #(
   parameter int LANES = 3,
   parameter int AW    = 64,
   parameter int SW    = 16,
   parameter int ISZ   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LANES-1:0]    in_valid,
   input  logic [2*LANES-1:0]  in_cause,
   input  logic [AW*LANES-1:0] in_pc,
   input  logic [AW*LANES-1:0] in_npc,
   input  logic [AW*LANES-1:0] in_nnpc,
   input  logic [SW*LANES-1:0] in_seq,
   output logic                rd_squash,
   output logic                rd_mispredict,
   output logic                rd_taken,
   output logic                rd_squash_ds,
   output logic [AW-1:0]       rd_pc,
   output logic [AW-1:0]       rd_npc,
   output logic [SW-1:0]       rd_seq,
   output logic                rd_incl_self
);
   localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (AW < 16) begin : g_bad_aw
      $error("AW must be at least 16");
   end
   if (ISZ < 1 || (ISZ & (ISZ - 1)) != 0) begin : g_bad_isz
      $error("ISZ must be a power of two");
   end

   logic [LANES-1:0] l_req, l_mp, l_tk, l_ds, l_inc;
   logic [AW-1:0]    l_rpc  [LANES];
   logic [AW-1:0]    l_rnpc [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sqr_lane_decode #(.AW(AW), .ISZ(ISZ)) u_dec (
         .valid     (in_valid[g]),
         .cause     (in_cause[2*g +: 2]),
         .pc        (in_pc[g*AW +: AW]),
         .npc       (in_npc[g*AW +: AW]),
         .nnpc      (in_nnpc[g*AW +: AW]),
         .req       (l_req[g]),
         .mispred   (l_mp[g]),
         .taken     (l_tk[g]),
         .squash_ds (l_ds[g]),
         .incl_self (l_inc[g]),
         .rpc       (l_rpc[g]),
         .rnpc      (l_rnpc[g])
      );
   end

   logic          pick_any;
   logic [IW-1:0] pick_idx;

   sqr_oldest_pick #(.LANES(LANES), .SW(SW)) u_pick (
      .req (l_req),
      .seq (in_seq),
      .any (pick_any),
      .idx (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_squash     <= 1'b0;
         rd_mispredict <= 1'b0;
         rd_taken      <= 1'b0;
         rd_squash_ds  <= 1'b0;
         rd_incl_self  <= 1'b0;
         rd_pc         <= '0;
         rd_npc        <= '0;
         rd_seq        <= '0;
      end else if (pick_any) begin
         rd_squash     <= 1'b1;
         rd_mispredict <= l_mp[pick_idx];
         rd_taken      <= l_tk[pick_idx];
         rd_squash_ds  <= l_ds[pick_idx];
         rd_incl_self  <= l_inc[pick_idx];
         rd_pc         <= l_rpc[pick_idx];
         rd_npc        <= l_rnpc[pick_idx];
         rd_seq        <= in_seq[pick_idx*SW +: SW];
      end else begin
         rd_squash     <= 1'b0;
         rd_mispredict <= 1'b0;
         rd_taken      <= 1'b0;
         rd_squash_ds  <= 1'b0;
         rd_incl_self  <= 1'b0;
         rd_pc         <= '0;
         rd_npc        <= '0;
         rd_seq        <= '0;
      end
   end

   // R3: a mispredict record always squashes the delay slot
   p_mispred_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mispredict |-> (rd_squash && rd_squash_ds && !rd_incl_self));

   // R4/R5: memory causes carry no branch flags
   p_mem_no_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_squash && !rd_mispredict) |-> (!rd_taken && !rd_squash_ds));

   // R5: include-self only for a non-branch squash
   p_incl_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_incl_self |-> (rd_squash && !rd_mispredict));

   // R6: no request from any lane means no record next cycle
   p_idle_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_any |=> !rd_squash);

   // R1: a quiet record has all flags low
   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_squash |-> !(rd_mispredict || rd_taken || rd_squash_ds || rd_incl_self));
endmodule

// File: tb/squash_redirect_gen_test.sv
module squash_redirect_gen_test;
   localparam int L  = 3;
   localparam int AW = 64;
   localparam int SW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [L-1:0]    in_valid;
   logic [2*L-1:0]  in_cause;
   logic [AW*L-1:0] in_pc, in_npc, in_nnpc;
   logic [SW*L-1:0] in_seq;
   logic rd_squash, rd_mispredict, rd_taken, rd_squash_ds, rd_incl_self;
   logic [AW-1:0] rd_pc, rd_npc;
   logic [SW-1:0] rd_seq;

   squash_redirect_gen #(.LANES(L), .AW(AW), .SW(SW), .ISZ(4)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cause(in_cause),
      .in_pc(in_pc), .in_npc(in_npc), .in_nnpc(in_nnpc), .in_seq(in_seq),
      .rd_squash(rd_squash), .rd_mispredict(rd_mispredict), .rd_taken(rd_taken),
      .rd_squash_ds(rd_squash_ds), .rd_pc(rd_pc), .rd_npc(rd_npc),
      .rd_seq(rd_seq), .rd_incl_self(rd_incl_self));

   // staging (set by stimulus) and drive (applied at negedge)
   logic          s_v [L];
   logic [1:0]    s_c [L];
   logic [AW-1:0] s_p [L], s_n [L], s_nn [L];
   logic [SW-1:0] s_s [L];
   logic          d_v [L];
   logic [1:0]    d_c [L];
   logic [AW-1:0] d_p [L], d_n [L], d_nn [L];
   logic [SW-1:0] d_s [L];

   always_comb begin
      for (int i = 0; i < L; i++) begin
         in_valid[i]          = d_v[i];
         in_cause[2*i +: 2]   = d_c[i];
         in_pc[i*AW +: AW]    = d_p[i];
         in_npc[i*AW +: AW]   = d_n[i];
         in_nnpc[i*AW +: AW]  = d_nn[i];
         in_seq[i*SW +: SW]   = d_s[i];
      end
   end

   typedef struct {
      bit sq, mp, tk, ds, inc;
      logic [AW-1:0] pc, npc;
      logic [SW-1:0] seq;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   function automatic bit ref_taken(logic [AW-1:0] p, logic [AW-1:0] n, logic [AW-1:0] nn);
      return !((nn == n + 64'd4) && ((n == p + 64'd4) || (n == p + 64'd8)));
   endfunction

   function automatic exp_t ref_record(string tag);
      exp_t e;
      int best;
      best = -1;
      for (int i = 0; i < L; i++)
         if (s_v[i] && s_c[i] != 2'd3 && (best < 0 || s_s[i] < s_s[best])) best = i;
      e.tag = tag;
      e.sq = 0; e.mp = 0; e.tk = 0; e.ds = 0; e.inc = 0;
      e.pc = '0; e.npc = '0; e.seq = '0;
      if (best >= 0) begin
         e.sq = 1; e.seq = s_s[best];
         case (s_c[best])
            2'd0: begin e.mp = 1; e.ds = 1; e.tk = ref_taken(s_p[best], s_n[best], s_nn[best]);
                        e.pc = s_n[best]; e.npc = s_nn[best]; end
            2'd1: begin e.pc = s_n[best]; e.npc = s_nn[best]; end
            default: begin e.inc = 1; e.pc = s_p[best]; e.npc = s_n[best]; end
         endcase
      end
      return e;
   endfunction

   task automatic clear_stage();
      for (int i = 0; i < L; i++) begin
         s_v[i] = 0; s_c[i] = 2'd3; s_p[i] = '0; s_n[i] = '0; s_nn[i] = '0; s_s[i] = '0;
      end
   endtask

   task automatic send(string tag);
      @(negedge clk);
      for (int i = 0; i < L; i++) begin
         d_v[i] = s_v[i]; d_c[i] = s_c[i]; d_p[i] = s_p[i];
         d_n[i] = s_n[i]; d_nn[i] = s_nn[i]; d_s[i] = s_s[i];
      end
      q.push_back(ref_record(tag));
   endtask

   task automatic lane(int i, logic [1:0] c, logic [AW-1:0] p, logic [AW-1:0] n,
                       logic [AW-1:0] nn, logic [SW-1:0] s);
      s_v[i] = 1; s_c[i] = c; s_p[i] = p; s_n[i] = n; s_nn[i] = nn; s_s[i] = s;
   endtask

   // monitor: record for item pushed at negedge appears after the next posedge
   always @(posedge clk) begin
      #1;
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (rd_squash !== e.sq || rd_mispredict !== e.mp || rd_taken !== e.tk ||
             rd_squash_ds !== e.ds || rd_incl_self !== e.inc || rd_pc !== e.pc ||
             rd_npc !== e.npc || rd_seq !== e.seq) begin
            errors++;
            $display("FAIL %s: got sq=%0b mp=%0b tk=%0b ds=%0b inc=%0b pc=%h npc=%h seq=%0d exp sq=%0b mp=%0b tk=%0b ds=%0b inc=%0b pc=%h npc=%h seq=%0d",
               e.tag, rd_squash, rd_mispredict, rd_taken, rd_squash_ds, rd_incl_self,
               rd_pc, rd_npc, rd_seq, e.sq, e.mp, e.tk, e.ds, e.inc, e.pc, e.npc, e.seq);
         end
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hang exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      clear_stage();
      for (int i = 0; i < L; i++) begin
         d_v[i] = 1; d_c[i] = 2'd0; d_p[i] = 64'h100; d_n[i] = 64'h200; d_nn[i] = 64'h300; d_s[i] = 16'd1;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (rd_squash !== 0 || rd_mispredict !== 0 || rd_incl_self !== 0 || rd_pc !== 0 || rd_seq !== 0) begin
         errors++;
         $display("FAIL R1 reset: got sq=%0b pc=%h exp sq=0 pc=0", rd_squash, rd_pc);
      end
      for (int i = 0; i < L; i++) d_v[i] = 0;
      rst_n = 1'b1;

      // R2 not-taken: one-word fall-through
      clear_stage(); lane(0, 2'd0, 64'h1000, 64'h1004, 64'h1008, 16'd5); send("R2 seq+4");
      // R2 not-taken: two-word skip
      clear_stage(); lane(0, 2'd0, 64'h1000, 64'h1008, 64'h100C, 16'd5); send("R2 seq+8");
      // R2 taken: NNPC breaks sequence
      clear_stage(); lane(1, 2'd0, 64'h2000, 64'h2004, 64'h4000, 16'd6); send("R2 R3 target");
      // R2 taken: NPC step of three words
      clear_stage(); lane(2, 2'd0, 64'h2000, 64'h200C, 64'h2010, 16'd6); send("R2 step12");
      // R6: idle cycle ends the record
      clear_stage(); send("R6 idle");
      // R4 memory order
      clear_stage(); lane(0, 2'd1, 64'h3000, 64'h3004, 64'h3008, 16'd9); send("R4 memorder");
      // R5 blocked access
      clear_stage(); lane(1, 2'd2, 64'h5000, 64'h5004, 64'h5008, 16'd10); send("R5 blocked");
      // R6 back-to-back squashes
      clear_stage(); lane(2, 2'd1, 64'h6000, 64'h6008, 64'h600C, 16'd11); send("R6 b2b");
      // R7 oldest wins over lane order
      clear_stage();
      lane(0, 2'd0, 64'h7000, 64'h7004, 64'h7008, 16'd40);
      lane(1, 2'd2, 64'h8000, 64'h8004, 64'h8008, 16'd12);
      lane(2, 2'd1, 64'h9000, 64'h9004, 64'h9008, 16'd30);
      send("R7 R9 oldest");
      // R7 tie: lowest lane
      clear_stage();
      lane(1, 2'd1, 64'hA000, 64'hA004, 64'hA008, 16'd7);
      lane(2, 2'd2, 64'hB000, 64'hB004, 64'hB008, 16'd7);
      send("R7 tie");
      // R8 cause 3 is ignored even if oldest
      clear_stage();
      lane(0, 2'd3, 64'hC000, 64'hC004, 64'hC008, 16'd1);
      lane(2, 2'd2, 64'hD000, 64'hD004, 64'hD008, 16'd50);
      send("R8 code3");
      // R8 invalid lane ignored
      clear_stage();
      lane(1, 2'd0, 64'hE000, 64'hE004, 64'hE008, 16'd0); s_v[1] = 0;
      send("R8 invalid");
      // R8 only code 3 everywhere
      clear_stage();
      for (int i = 0; i < L; i++) lane(i, 2'd3, 64'hF000, 64'hF004, 64'hF008, 16'd2);
      send("R8 allnone");

      // randomized triples
      for (int k = 0; k < 600; k++) begin
         clear_stage();
         for (int i = 0; i < L; i++) begin
            logic [AW-1:0] p, n, nn;
            int m;
            p = {$urandom, $urandom} & ~64'h3;
            m = $urandom % 5;
            n = (m == 1) ? p + 64'd8 : (m == 0 || m == 2) ? p + 64'd4 : {$urandom, $urandom} & ~64'h3;
            nn = (m == 2 || m == 4) ? ({$urandom, $urandom} & ~64'h3) : n + 64'd4;
            lane(i, 2'($urandom % 4), p, n, nn, 16'($urandom % 8));
            s_v[i] = ($urandom % 4) != 0;
         end
         send("R2 R3 R4 R5 R7 R9 random");
      end
      clear_stage(); send("R6 final idle");
      repeat (3) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule